// File: doc/BRIEF.md
# Match-Compare Watchdog Reset Controller

This block is a watchdog timer that sits on a simple 32-bit register bus. A free-running up-counter advances once per clock while enabled, and its value is compared with a programmable match value. When the two are equal, the block can take any mix of these actions: raise an interrupt flag, stop the counter and return it to zero, drive a match output pin to a chosen level, request a one-cycle internal chip reset, or pull an active-low external reset pin for a programmed number of clocks.

Software can also fire either reset at once through self-clearing force bits. Setting the match output bit from software, with internal-reset-on-match enabled, gives an internal-only restart that leaves the external pin alone. A debug-halt input can freeze the count. A sticky status flag records that the block caused a reset, and only the power-on reset clears it.

Registers sit at word-aligned byte offsets: 0x00 interrupt flag, 0x04 control, 0x08 counter, 0x0C match actions, 0x10 match value, 0x14 match output, 0x18 pulse length, 0x1C reset status.

Top module: `wdt_match_reset`

## Requirements
- R1: After power-on reset, every register at offsets 0x00 to 0x1C reads zero, irq, matchOut and intRstReq are low, and extRstN is high.
- R2: Control (0x04) bit 0 makes the counter go up by one each clock. If control bit 2 is set and debugHalt is high, the counter holds its value. With bit 2 clear, debugHalt has no effect.
- R3: While control bit 1 is set, the counter is zero and does not count, so a read of 0x08 returns zero one clock after the write.
- R4: A match is the counter equal to the match value (0x10) in a cycle where counting is active. If the stop action is off, the counter keeps counting past the match, and the match acts only once.
- R5: Match-action (0x0C) bit 0 makes a match set interrupt bit 0 (0x00), which drives irq. Writing 1 to that bit clears it. Writing 0 leaves it unchanged.
- R6: Match-action bit 2 makes a match return the counter to zero and clear control bit 0, so counting stops.
- R7: Match-output register (0x14) bits 5:4 choose what a match does to bit 0: 0 leaves it, 1 clears it, 2 sets it, 3 inverts it. Software can write and read bit 0 directly, and matchOut follows it.
- R8: extRstN goes low from the clock edge after a trigger and stays low for pulse length (0x18) plus 6 clocks. A trigger is a match with match-action bit 4 set, or a write of 1 to match-action bit 6. A trigger that arrives during a pulse is ignored.
- R9: intRstReq goes high for one clock after any of these triggers: a match with match-action bit 3 set, a write of 1 to match-action bit 5, or a software write that takes match-output bit 0 from 0 to 1 while match-action bit 3 is set. The software path does not pull extRstN low.
- R10: Reset-status bit 0 (0x1C) is set by every internal or external reset trigger. Bus writes do not change it, and only porRstN clears it.
- R11: Reads of undefined or unaligned addresses return zero, and writes to them are ignored. The counter is read-only. Match-action bits 1, 5 and 6 read back as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Counter and register clock |
| porRstN | input | 1 | Asynchronous power-on reset, active low |
| busSel | input | 1 | Bus access in this cycle |
| busWr | input | 1 | 1 = write, 0 = read |
| busAddr | input | ADDR_W | Byte address |
| busWData | input | 32 | Write data |
| busRData | output | 32 | Read data, combinational from busAddr |
| debugHalt | input | 1 | Debugger halt indication |
| irq | output | 1 | Match interrupt flag |
| matchOut | output | 1 | Match output state |
| intRstReq | output | 1 | One-clock internal reset request |
| extRstN | output | 1 | External reset, active low |

## Verification
The bench builds the block with an 8-bit counter and a 6-bit pulse length. This makes every pulse length from 0 to 63 reachable, so the bench measures the external reset width for each one against length plus six. The narrow counter also keeps match values up to the top of the counter range within a few hundred cycles, so the match, interrupt and stop timing is checked at the exact cycle for values spread across that range. All four match-output modes are checked from both starting levels.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

  localparam int OFS_W = 3;

  localparam logic [OFS_W-1:0] W_INT   = 3'd0;
  localparam logic [OFS_W-1:0] W_CTRL  = 3'd1;
  localparam logic [OFS_W-1:0] W_CNT   = 3'd2;
  localparam logic [OFS_W-1:0] W_MACT  = 3'd3;
  localparam logic [OFS_W-1:0] W_MATCH = 3'd4;
  localparam logic [OFS_W-1:0] W_MOUT  = 3'd5;
  localparam logic [OFS_W-1:0] W_PULSE = 3'd6;
  localparam logic [OFS_W-1:0] W_RSTAT = 3'd7;

  typedef enum logic [1:0] {
    MO_KEEP   = 2'd0,
    MO_LOW    = 2'd1,
    MO_HIGH   = 2'd2,
    MO_TOGGLE = 2'd3
  } matchOutMode_e;

  // Configuration levels and one-cycle strobes from control to datapath.
  typedef struct packed {
    logic          cntEn;
    logic          cntClr;
    logic          dbgFreeze;
    logic          irqOnMatch;
    logic          stopOnMatch;
    logic          intOnMatch;
    logic          extOnMatch;
    matchOutMode_e moMode;
    logic          flagClr;
    logic          moWr;
    logic          moWrVal;
    logic          forceInt;
    logic          forceExt;
  } wdtStrobe_t;

endpackage

// File: rtl/wdt_ctrl.sv
module wdt_ctrl
  import wdt_pkg::*;
#(
  parameter int CNT_W   = 32,
  parameter int PULSE_W = 16,
  parameter int ADDR_W  = 8
) (
  input  logic               clk,
  input  logic               porRstN,
  input  logic               busSel,
  input  logic               busWr,
  input  logic [ADDR_W-1:0]  busAddr,
  input  logic [31:0]        busWData,
  output logic [31:0]        busRData,
  input  logic [CNT_W-1:0]   cntVal,
  input  logic               intFlag,
  input  logic               matchOut,
  input  logic               resStatus,
  input  logic               matchHit,
  output wdtStrobe_t         strobe,
  output logic [CNT_W-1:0]   matchVal,
  output logic [PULSE_W-1:0] pulseLen
);

  logic [OFS_W-1:0] wordIdx;
  logic             inRange;
  logic             wrAny;
  logic wrInt, wrCtrl, wrMact, wrMatch, wrMout, wrPulse;

  assign wordIdx = busAddr[4:2];
  assign inRange = (busAddr[ADDR_W-1:5] == '0) && (busAddr[1:0] == 2'b00);
  assign wrAny   = busSel && busWr && inRange;

  assign wrInt   = wrAny && (wordIdx == W_INT);
  assign wrCtrl  = wrAny && (wordIdx == W_CTRL);
  assign wrMact  = wrAny && (wordIdx == W_MACT);
  assign wrMatch = wrAny && (wordIdx == W_MATCH);
  assign wrMout  = wrAny && (wordIdx == W_MOUT);
  assign wrPulse = wrAny && (wordIdx == W_PULSE);

  logic          ctrlEn, ctrlClr, ctrlDbg;
  logic          actIrq, actStop, actInt, actExt;
  matchOutMode_e moMode;

  always_ff @(posedge clk or negedge porRstN) begin
    if (!porRstN) begin
      ctrlEn  <= 1'b0;
      ctrlClr <= 1'b0;
      ctrlDbg <= 1'b0;
    end else if (wrCtrl) begin
      ctrlEn  <= busWData[0];
      ctrlClr <= busWData[1];
      ctrlDbg <= busWData[2];
    end else if (matchHit && actStop) begin
      ctrlEn  <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge porRstN) begin
    if (!porRstN) begin
      actIrq  <= 1'b0;
      actStop <= 1'b0;
      actInt  <= 1'b0;
      actExt  <= 1'b0;
    end else if (wrMact) begin
      actIrq  <= busWData[0];
      actStop <= busWData[2];
      actInt  <= busWData[3];
      actExt  <= busWData[4];
    end
  end

  always_ff @(posedge clk or negedge porRstN) begin
    if (!porRstN) begin
      matchVal <= '0;
      pulseLen <= '0;
      moMode   <= MO_KEEP;
    end else begin
      if (wrMatch) matchVal <= busWData[CNT_W-1:0];
      if (wrPulse) pulseLen <= busWData[PULSE_W-1:0];
      if (wrMout)  moMode   <= matchOutMode_e'(busWData[5:4]);
    end
  end

  always_comb begin
    strobe.cntEn       = ctrlEn;
    strobe.cntClr      = ctrlClr;
    strobe.dbgFreeze   = ctrlDbg;
    strobe.irqOnMatch  = actIrq;
    strobe.stopOnMatch = actStop;
    strobe.intOnMatch  = actInt;
    strobe.extOnMatch  = actExt;
    strobe.moMode      = moMode;
    strobe.flagClr     = wrInt && busWData[0];
    strobe.moWr        = wrMout;
    strobe.moWrVal     = busWData[0];
    strobe.forceInt    = wrMact && busWData[5];
    strobe.forceExt    = wrMact && busWData[6];
  end

  always_comb begin
    busRData = '0;
    if (inRange) begin
      unique case (wordIdx)
        W_INT:   busRData = {31'd0, intFlag};
        W_CTRL:  busRData = {29'd0, ctrlDbg, ctrlClr, ctrlEn};
        W_CNT:   busRData = 32'(cntVal);
        W_MACT:  busRData = {27'd0, actExt, actInt, actStop, 1'b0, actIrq};
        W_MATCH: busRData = 32'(matchVal);
        W_MOUT:  busRData = {26'd0, moMode, 3'd0, matchOut};
        W_PULSE: busRData = 32'(pulseLen);
        W_RSTAT: busRData = {31'd0, resStatus};
        default: busRData = '0;
      endcase
    end
  end

  AST_STOP_CLEARS_ENABLE: assert property (@(posedge clk) disable iff (!porRstN)
    (matchHit && actStop && !wrCtrl) |=> !ctrlEn); // R6

  AST_FORCE_NOT_STORED: assert property (@(posedge clk) disable iff (!porRstN)
    wrMact |=> (busRData[6:5] == 2'b00 || !(busSel && !busWr && inRange && wordIdx == W_MACT))); // R11

endmodule

// File: rtl/wdt_datapath.sv
module wdt_datapath
  import wdt_pkg::*;
#(
  parameter int CNT_W       = 32,
  parameter int PULSE_W     = 16,
  parameter int PULSE_EXTRA = 6
) (
  input  logic               clk,
  input  logic               porRstN,
  input  wdtStrobe_t         st,
  input  logic [CNT_W-1:0]   matchVal,
  input  logic [PULSE_W-1:0] pulseLen,
  input  logic               debugHalt,
  output logic [CNT_W-1:0]   cnt,
  output logic               matchHit,
  output logic               intFlag,
  output logic               matchOut,
  output logic               intRstReq,
  output logic               extRstN,
  output logic               resStatus
);

  localparam int XW = PULSE_W + $clog2(PULSE_EXTRA + 1);

  logic cntActive;
  logic swRise;
  logic intTrig, extTrig;
  logic extActive;
  logic [XW-1:0] extLeft;

  assign cntActive = st.cntEn && !st.cntClr && !(st.dbgFreeze && debugHalt);
  assign matchHit  = cntActive && (cnt == matchVal);

  always_ff @(posedge clk or negedge porRstN) begin
    if (!porRstN)                         cnt <= '0;
    else if (st.cntClr)                   cnt <= '0;
    else if (matchHit && st.stopOnMatch)  cnt <= '0;
    else if (cntActive)                   cnt <= cnt + 1'b1;
  end

  always_ff @(posedge clk or negedge porRstN) begin
    if (!porRstN)                           intFlag <= 1'b0;
    else if (matchHit && st.irqOnMatch)     intFlag <= 1'b1;
    else if (st.flagClr)                    intFlag <= 1'b0;
  end

  always_ff @(posedge clk or negedge porRstN) begin
    if (!porRstN) begin
      matchOut <= 1'b0;
    end else if (st.moWr) begin
      matchOut <= st.moWrVal;
    end else if (matchHit) begin
      unique case (st.moMode)
        MO_LOW:    matchOut <= 1'b0;
        MO_HIGH:   matchOut <= 1'b1;
        MO_TOGGLE: matchOut <= ~matchOut;
        default:   matchOut <= matchOut;
      endcase
    end
  end

  assign swRise  = st.moWr && st.moWrVal && !matchOut;
  assign intTrig = st.forceInt || (st.intOnMatch && (matchHit || swRise));
  assign extTrig = st.forceExt || (st.extOnMatch && matchHit);

  always_ff @(posedge clk or negedge porRstN) begin
    if (!porRstN) begin
      intRstReq <= 1'b0;
      resStatus <= 1'b0;
    end else begin
      intRstReq <= intTrig;
      resStatus <= resStatus || intTrig || extTrig;
    end
  end

  always_ff @(posedge clk or negedge porRstN) begin
    if (!porRstN) begin
      extActive <= 1'b0;
      extLeft   <= '0;
    end else if (!extActive) begin
      if (extTrig) begin
        extActive <= 1'b1;
        extLeft   <= XW'(pulseLen) + XW'(PULSE_EXTRA - 1);
      end
    end else if (extLeft == '0) begin
      extActive <= 1'b0;
    end else begin
      extLeft   <= extLeft - 1'b1;
    end
  end

  assign extRstN = !extActive;

  AST_CLR_ZEROES_COUNT: assert property (@(posedge clk) disable iff (!porRstN)
    st.cntClr |=> (cnt == '0)); // R3

  AST_FREEZE_HOLDS: assert property (@(posedge clk) disable iff (!porRstN)
    (st.dbgFreeze && debugHalt && !st.cntClr) |=> $stable(cnt)); // R2

  AST_MATCH_RAISES_FLAG: assert property (@(posedge clk) disable iff (!porRstN)
    (matchHit && st.irqOnMatch) |=> intFlag); // R5

  AST_STATUS_STICKY: assert property (@(posedge clk) disable iff (!porRstN)
    resStatus |=> resStatus); // R10

  AST_EXT_SETS_STATUS: assert property (@(posedge clk) disable iff (!porRstN)
    !extRstN |-> resStatus); // R8

  AST_SW_INTERNAL_ONLY: assert property (@(posedge clk) disable iff (!porRstN)
    (swRise && st.intOnMatch && !st.forceExt && !matchHit && extRstN)
      |=> (intRstReq && extRstN)); // R9

endmodule

// File: rtl/wdt_match_reset.sv
module wdt_match_reset
  import wdt_pkg::*;
#(
  parameter int CNT_W       = 32,
  parameter int PULSE_W     = 16,
  parameter int PULSE_EXTRA = 6,
  parameter int ADDR_W      = 8
) (
  input  logic              clk,
  input  logic              porRstN,
  input  logic              busSel,
  input  logic              busWr,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [31:0]       busWData,
  output logic [31:0]       busRData,
  input  logic              debugHalt,
  output logic              irq,
  output logic              matchOut,
  output logic              intRstReq,
  output logic              extRstN
);

  wdtStrobe_t         strobe;
  logic [CNT_W-1:0]   matchVal;
  logic [PULSE_W-1:0] pulseLen;
  logic [CNT_W-1:0]   cntVal;
  logic               matchHit;
  logic               intFlag;
  logic               resStatus;

  wdt_ctrl #(
    .CNT_W   (CNT_W),
    .PULSE_W (PULSE_W),
    .ADDR_W  (ADDR_W)
  ) uCtrl (
    .clk       (clk),
    .porRstN   (porRstN),
    .busSel    (busSel),
    .busWr     (busWr),
    .busAddr   (busAddr),
    .busWData  (busWData),
    .busRData  (busRData),
    .cntVal    (cntVal),
    .intFlag   (intFlag),
    .matchOut  (matchOut),
    .resStatus (resStatus),
    .matchHit  (matchHit),
    .strobe    (strobe),
    .matchVal  (matchVal),
    .pulseLen  (pulseLen)
  );

  wdt_datapath #(
    .CNT_W       (CNT_W),
    .PULSE_W     (PULSE_W),
    .PULSE_EXTRA (PULSE_EXTRA)
  ) uPath (
    .clk       (clk),
    .porRstN   (porRstN),
    .st        (strobe),
    .matchVal  (matchVal),
    .pulseLen  (pulseLen),
    .debugHalt (debugHalt),
    .cnt       (cntVal),
    .matchHit  (matchHit),
    .intFlag   (intFlag),
    .matchOut  (matchOut),
    .intRstReq (intRstReq),
    .extRstN   (extRstN),
    .resStatus (resStatus)
  );

  assign irq = intFlag;

endmodule

// File: tb/sim_wdt_match_reset.sv
module sim_wdt_match_reset;

  localparam int CLK_PERIOD = 10;
  localparam int CNT_W   = 8;
  localparam int PULSE_W = 6;
  localparam int ADDR_W  = 8;
  localparam int WATCHDOG_CYCLES = 100000;

  logic              clk = 1'b0;
  logic              porRstN = 1'b0;
  logic              busSel = 1'b0;
  logic              busWr = 1'b0;
  logic [ADDR_W-1:0] busAddr = '0;
  logic [31:0]       busWData = '0;
  logic [31:0]       busRData;
  logic              debugHalt = 1'b0;
  logic              irq, matchOut, intRstReq, extRstN;

  int total = 0;
  int bad = 0;
  int lowCycles = 0;
  int intPulses = 0;
  int cycles = 0;

  wdt_match_reset #(
    .CNT_W       (CNT_W),
    .PULSE_W     (PULSE_W),
    .PULSE_EXTRA (6),
    .ADDR_W      (ADDR_W)
  ) u0 (
    .clk       (clk),
    .porRstN   (porRstN),
    .busSel    (busSel),
    .busWr     (busWr),
    .busAddr   (busAddr),
    .busWData  (busWData),
    .busRData  (busRData),
    .debugHalt (debugHalt),
    .irq       (irq),
    .matchOut  (matchOut),
    .intRstReq (intRstReq),
    .extRstN   (extRstN)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(negedge clk) begin
    if (!extRstN)  lowCycles++;
    if (intRstReq) intPulses++;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > WATCHDOG_CYCLES) begin
      bad++;
      $display("FAIL watchdog: run hung, actual=%0d cycles expected<=%0d", cycles, WATCHDOG_CYCLES);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic check(input string tag, input longint act, input longint exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [ADDR_W-1:0] a, input logic [31:0] d);
    @(negedge clk);
    busSel = 1'b1; busWr = 1'b1; busAddr = a; busWData = d;
    @(negedge clk);
    busSel = 1'b0; busWr = 1'b0; busWData = '0;
  endtask

  task automatic rd(input logic [ADDR_W-1:0] a, output logic [31:0] d);
    busSel = 1'b1; busWr = 1'b0; busAddr = a;
    #1;
    d = busRData;
    busSel = 1'b0;
  endtask

  task automatic waitN(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    logic [31:0] v, v0;
    repeat (3) @(negedge clk);
    porRstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    for (int a = 0; a < 8; a++) begin
      rd(ADDR_W'(a * 4), v);
      check("R1 register after reset", v, 0);
    end
    check("R1 irq", irq, 0);
    check("R1 matchOut", matchOut, 0);
    check("R1 intRstReq", intRstReq, 0);
    check("R1 extRstN", extRstN, 1);

    // R3 clear holds zero even with enable
    wr(8'h04, 32'h2); waitN(1);
    rd(8'h08, v); check("R3 counter after clear", v, 0);
    wr(8'h04, 32'h3); waitN(4);
    rd(8'h08, v); check("R3 clear suppresses counting", v, 0);

    // R2 counting and freeze
    wr(8'h04, 32'h1); waitN(5);
    rd(8'h08, v); check("R2 counts one per clock", v, 5);
    debugHalt = 1'b1;
    wr(8'h04, 32'h5);
    rd(8'h08, v0); waitN(4);
    rd(8'h08, v); check("R2 frozen during halt", v, v0);
    debugHalt = 1'b0; waitN(3);
    rd(8'h08, v); check("R2 resumes after halt", v, v0 + 3);
    debugHalt = 1'b1;
    wr(8'h04, 32'h1);
    rd(8'h08, v0); waitN(4);
    rd(8'h08, v); check("R2 halt ignored without freeze bit", v, v0 + 4);
    debugHalt = 1'b0;

    // R5 R6 sweep over match values, exact match cycle
    foreach (v0[i]) begin end
    for (int k = 0; k < 6; k++) begin
      int m;
      m = (k == 0) ? 0 : (k == 1) ? 1 : (k == 2) ? 5 : (k == 3) ? 37 : (k == 4) ? 200 : 255;
      wr(8'h04, 32'h2);
      wr(8'h10, 32'(m));
      wr(8'h0C, 32'h5);
      wr(8'h00, 32'h1);
      wr(8'h04, 32'h1);
      waitN(m);
      check("R5 irq low before match", irq, 0);
      waitN(1);
      check("R5 irq set on match", irq, 1);
      waitN(2);
      rd(8'h08, v); check("R6 counter zero after stop", v, 0);
      rd(8'h04, v); check("R6 enable cleared by match", v, 0);
    end
    wr(8'h00, 32'h0);
    check("R5 write 0 keeps flag", irq, 1);
    wr(8'h00, 32'h1);
    check("R5 write 1 clears flag", irq, 0);

    // R4 single action, counting continues
    wr(8'h04, 32'h2);
    wr(8'h10, 32'h3);
    wr(8'h0C, 32'h1);
    wr(8'h04, 32'h1);
    waitN(6);
    check("R4 match flag", irq, 1);
    wr(8'h00, 32'h1);
    waitN(40);
    check("R4 match acts once", irq, 0);
    rd(8'h08, v0); waitN(10);
    rd(8'h08, v); check("R4 counting continues past match", v, v0 + 10);

    // R7 match output modes from both start levels
    for (int mode = 0; mode < 4; mode++) begin
      for (int b = 0; b < 2; b++) begin
        int expBit;
        expBit = (mode == 0) ? b : (mode == 1) ? 0 : (mode == 2) ? 1 : (1 - b);
        wr(8'h04, 32'h2);
        wr(8'h0C, 32'h4);
        wr(8'h10, 32'h2);
        wr(8'h14, 32'((mode << 4) | b));
        check("R7 software written bit", matchOut, b);
        wr(8'h04, 32'h1);
        waitN(8);
        rd(8'h14, v);
        check("R7 output register after match", v, (mode << 4) | expBit);
        check("R7 matchOut pin", matchOut, expBit);
      end
    end
    rd(8'h1C, v); check("R10 no trigger yet", v, 0);
    check("R8 no pulse yet", lowCycles, 0);

    // R8 exhaustive pulse length sweep via force
    wr(8'h04, 32'h2);
    wr(8'h0C, 32'h0);
    for (int p = 0; p < 64; p++) begin
      wr(8'h18, 32'(p));
      lowCycles = 0;
      wr(8'h0C, 32'h40);
      while (extRstN == 1'b0) @(negedge clk);
      check("R8 forced pulse width", lowCycles, p + 6);
    end
    rd(8'h1C, v); check("R10 status set by external reset", v, 1);

    // R8 retrigger during pulse ignored
    wr(8'h18, 32'd10);
    lowCycles = 0;
    wr(8'h0C, 32'h40);
    waitN(2);
    wr(8'h0C, 32'h40);
    while (extRstN == 1'b0) @(negedge clk);
    check("R8 retrigger ignored", lowCycles, 16);

    // R8 pulse from match
    wr(8'h18, 32'd3);
    wr(8'h10, 32'd4);
    wr(8'h0C, 32'h14);
    lowCycles = 0; intPulses = 0;
    wr(8'h04, 32'h1);
    waitN(20);
    check("R8 match pulse width", lowCycles, 9);
    check("R9 no internal request without bit 3", intPulses, 0);

    // R9 forced internal reset
    wr(8'h04, 32'h2);
    lowCycles = 0; intPulses = 0;
    wr(8'h0C, 32'h20);
    waitN(3);
    check("R9 forced internal pulse", intPulses, 1);
    check("R9 force internal leaves pin", lowCycles, 0);

    // R9 software-set match output path
    wr(8'h0C, 32'h8);
    wr(8'h14, 32'h0);
    lowCycles = 0; intPulses = 0;
    wr(8'h14, 32'h1);
    waitN(3);
    check("R9 software set gives internal reset", intPulses, 1);
    check("R9 software set leaves external pin", lowCycles, 0);
    wr(8'h14, 32'h1);
    waitN(3);
    check("R9 no rise no request", intPulses, 1);
    wr(8'h0C, 32'h0);
    wr(8'h14, 32'h0);
    wr(8'h14, 32'h1);
    waitN(3);
    check("R9 no request without bit 3", intPulses, 1);

    // R9 internal reset on match
    wr(8'h10, 32'd2);
    wr(8'h0C, 32'hC);
    intPulses = 0; lowCycles = 0;
    wr(8'h04, 32'h1);
    waitN(8);
    check("R9 match internal pulse", intPulses, 1);
    check("R9 match internal only", lowCycles, 0);

    // R11 undefined / unaligned access, read-only fields
    wr(8'h04, 32'h2);
    wr(8'h10, 32'h5A);
    wr(8'h20, 32'hFFFF_FFFF);
    wr(8'h3C, 32'hFFFF_FFFF);
    wr(8'h11, 32'hFFFF_FFFF);
    rd(8'h10, v); check("R11 undefined writes ignored", v, 32'h5A);
    rd(8'h20, v); check("R11 undefined read zero", v, 0);
    rd(8'h12, v); check("R11 unaligned read zero", v, 0);
    wr(8'h08, 32'h55);
    rd(8'h08, v); check("R11 counter read-only", v, 0);
    wr(8'h0C, 32'h1F);
    rd(8'h0C, v); check("R11 action readback", v, 32'h1D);
    wr(8'h0C, 32'h0);

    // R10 sticky and power-on clear
    wr(8'h1C, 32'h0);
    rd(8'h1C, v); check("R10 write does not clear", v, 1);
    @(negedge clk); porRstN = 1'b0;
    @(negedge clk); porRstN = 1'b1;
    @(negedge clk);
    rd(8'h1C, v); check("R10 cleared by power-on reset", v, 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule